// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer with Fault Signalling

This block sits between address generation and the data memory access. It holds a few recent virtual-to-physical page translations. Each request brings a virtual address and an access kind. On a hit, the block returns the physical address in the same cycle and checks the entry's write permission. On a miss, it stops answering lookups and raises a refill request for the missed page. It then waits for a refill response. The response either installs a translation or reports that the page is absent, which raises a one-cycle page-fault pulse.

Pages are 4 KB, so the low 12 address bits pass through untranslated. The victim entry for a refill is chosen as follows: a free entry first, then an entry whose reference bit is clear, and otherwise entry 0. A hit sets the entry's reference bit. A periodic clear input wipes all reference bits. A flush input invalidates every entry for a process switch.

The controller has three named states:
- `ST_RUN`: lookups are answered.
- `ST_WAIT`: a refill is outstanding.
- `ST_FAULT`: a one-cycle page-fault report.

Its transitions are:
- RUN to WAIT, on a missing request.
- WAIT to RUN, on a present refill.
- WAIT to FAULT, on an absent refill.
- FAULT to RUN, unconditionally.
- Any state to RUN, on flush.

Top module: `tlb_xlate`

## Requirements
- R1: On a hit, `resp_paddr` is the entry's physical page number followed by the untouched low 12 bits of `req_vaddr`, in the same cycle as the request.
- R2: A hit needs a valid entry whose tag equals `req_vaddr[31:12]`. After reset no entry is valid, so every request in `ST_RUN` gives `resp_miss`=1 and `resp_hit`=0.
- R3: Access kinds are encoded as 0 fetch, 1 load, 2 store. A store that hits a read-only entry gives `prot_fault`=1 and `resp_grant`=0. Any other hit gives `resp_grant`=1 and `prot_fault`=0.
- R4: A missing request in `ST_RUN` makes `refill_req`=1 from the next cycle, with `refill_vpn` equal to the missed page number. This holds until a refill response or a flush.
- R5: A refill response with `fill_present`=1 installs `fill_ppn` and `fill_writable` at the next edge. A following request to that page hits.
- R6: A refill response with `fill_present`=0 installs nothing. It raises `page_fault` for exactly the one following cycle.
- R7: A refill is placed in the lowest-index invalid entry, if any entry is invalid.
- R8: When all entries are valid, the victim is the lowest-index entry whose reference bit is clear. A hit and an installation both set the entry's reference bit.
- R9: When all entries are valid and all reference bits are set, entry 0 is replaced.
- R10: `ref_clear` zeroes every reference bit at the next edge.
- R11: `flush` invalidates every entry in one cycle and abandons an outstanding refill. The controller returns to `ST_RUN` and `refill_req` drops.
- R12: Outside `ST_RUN`, requests are ignored: `resp_hit` and `resp_miss` both stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request present |
| req_vaddr | input | 32 | Virtual address |
| req_kind | input | 2 | Access kind: 0 fetch, 1 load, 2 store |
| resp_hit | output | 1 | Translation found |
| resp_miss | output | 1 | No translation found |
| resp_grant | output | 1 | Hit and access permitted |
| prot_fault | output | 1 | Store to a read-only page |
| resp_paddr | output | 32 | Physical address (valid on hit) |
| refill_req | output | 1 | Refill outstanding |
| refill_vpn | output | 20 | Page number to refill |
| fill_valid | input | 1 | Refill response present |
| fill_present | input | 1 | Page is mapped and resident |
| fill_ppn | input | 20 | Physical page number to install |
| fill_writable | input | 1 | 1 read-write, 0 read-only |
| page_fault | output | 1 | One-cycle page-fault pulse |
| ref_clear | input | 1 | Zero all reference bits |
| flush | input | 1 | Invalidate all entries |

## Verification
The checker watches port-level rules on every cycle:
- offset pass-through on hits;
- exclusive hit and miss;
- the protection outcome of stores;
- the miss-to-refill handover with the latched page number;
- the single-cycle fault pulse;
- silence of lookups while a refill is outstanding;
- the collapse of pending work on flush.

Victim choice cannot be seen in one cycle. Neither can the effect of reference bits, of their periodic clear, or of a flush on stored entries. The bench scenarios expose these by filling, aging and flushing entries, then probing which pages still hit.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'd0,
        ACC_LOAD  = 2'd1,
        ACC_STORE = 2'd2
    } acc_kind_e;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_WAIT  = 2'd1,
        ST_FAULT = 2'd2
    } ctl_state_e;

endpackage

// File: rtl/tlb_entry_array.sv
module tlb_entry_array #(
    parameter int ENTRIES = 2,
    parameter int VPN_W   = 20,
    parameter int PPN_W   = 20,
    parameter int IDX_W   = 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [VPN_W-1:0]    lookup_vpn,
    input  logic                touch_en,
    input  logic                clear_refs,
    input  logic                flush_all,
    input  logic                inst_en,
    input  logic [IDX_W-1:0]    inst_idx,
    input  logic [VPN_W-1:0]    inst_vpn,
    input  logic [PPN_W-1:0]    inst_ppn,
    input  logic                inst_wr,
    output logic [ENTRIES-1:0]  hit_vec,
    output logic [PPN_W-1:0]    hit_ppn,
    output logic                hit_wr,
    output logic [ENTRIES-1:0]  valid_vec,
    output logic [ENTRIES-1:0]  ref_vec
);

    logic [ENTRIES-1:0][PPN_W-1:0] masked_ppn;
    logic [ENTRIES-1:0]            masked_wr;

    for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
        logic             vld_q;
        logic             ref_q;
        logic             wr_q;
        logic [VPN_W-1:0] tag_q;
        logic [PPN_W-1:0] ppn_q;
        logic             sel;

        assign sel = inst_en && (inst_idx == IDX_W'(i));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld_q <= 1'b0;
                ref_q <= 1'b0;
                wr_q  <= 1'b0;
                tag_q <= '0;
                ppn_q <= '0;
            end else if (flush_all) begin
                vld_q <= 1'b0;
                ref_q <= 1'b0;
            end else if (sel) begin
                vld_q <= 1'b1;
                ref_q <= 1'b1;
                wr_q  <= inst_wr;
                tag_q <= inst_vpn;
                ppn_q <= inst_ppn;
            end else if (clear_refs) begin
                ref_q <= 1'b0;
            end else if (touch_en && hit_vec[i]) begin
                ref_q <= 1'b1;
            end
        end

        assign hit_vec[i]    = vld_q && (tag_q == lookup_vpn);
        assign valid_vec[i]  = vld_q;
        assign ref_vec[i]    = ref_q;
        assign masked_ppn[i] = hit_vec[i] ? ppn_q : '0;
        assign masked_wr[i]  = hit_vec[i] && wr_q;
    end

    always_comb begin
        hit_ppn = '0;
        for (int k = 0; k < ENTRIES; k++) begin
            hit_ppn = hit_ppn | masked_ppn[k];
        end
        hit_wr = |masked_wr;
    end

endmodule

// File: rtl/tlb_victim_pick.sv
module tlb_victim_pick #(
    parameter int ENTRIES = 2,
    parameter int IDX_W   = 1
) (
    input  logic [ENTRIES-1:0] valid_vec,
    input  logic [ENTRIES-1:0] ref_vec,
    output logic [IDX_W-1:0]   victim_idx
);

    logic             any_free;
    logic             any_cold;
    logic [IDX_W-1:0] free_idx;
    logic [IDX_W-1:0] cold_idx;

    always_comb begin
        any_free = 1'b0;
        any_cold = 1'b0;
        free_idx = '0;
        cold_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid_vec[i]) begin
                any_free = 1'b1;
                free_idx = IDX_W'(i);
            end
            if (!ref_vec[i]) begin
                any_cold = 1'b1;
                cold_idx = IDX_W'(i);
            end
        end
        if (any_free) begin
            victim_idx = free_idx;
        end else if (any_cold) begin
            victim_idx = cold_idx;
        end else begin
            victim_idx = '0;
        end
    end

endmodule

// File: rtl/tlb_ctrl.sv
module tlb_ctrl
    import tlb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic any_hit,
    input  logic fill_valid,
    input  logic fill_present,
    input  logic flush,
    output logic in_run,
    output logic capture,
    output logic inst_en,
    output logic refill_req,
    output logic page_fault
);

    ctl_state_e state_q;
    ctl_state_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (req_valid && !any_hit) state_d = ST_WAIT;
            end
            ST_WAIT: begin
                if (fill_valid) state_d = fill_present ? ST_RUN : ST_FAULT;
            end
            ST_FAULT: begin
                state_d = ST_RUN;
            end
            default: begin
                state_d = ST_RUN;
            end
        endcase
        if (flush) state_d = ST_RUN;
    end

    always_comb begin
        in_run     = 1'b0;
        capture    = 1'b0;
        inst_en    = 1'b0;
        refill_req = 1'b0;
        page_fault = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                in_run  = 1'b1;
                capture = req_valid && !any_hit;
            end
            ST_WAIT: begin
                refill_req = 1'b1;
                inst_en    = fill_valid && fill_present && !flush;
            end
            ST_FAULT: begin
                page_fault = 1'b1;
            end
            default: begin
                in_run = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
    import tlb_pkg::*;
#(
    parameter int ENTRIES   = 2,
    parameter int VPN_W     = 20,
    parameter int PPN_W     = 20,
    parameter int PAGE_BITS = 12,
    localparam int VA_W     = VPN_W + PAGE_BITS,
    localparam int PA_W     = PPN_W + PAGE_BITS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [VA_W-1:0]  req_vaddr,
    input  logic [1:0]       req_kind,
    output logic             resp_hit,
    output logic             resp_miss,
    output logic             resp_grant,
    output logic             prot_fault,
    output logic [PA_W-1:0]  resp_paddr,
    output logic             refill_req,
    output logic [VPN_W-1:0] refill_vpn,
    input  logic             fill_valid,
    input  logic             fill_present,
    input  logic [PPN_W-1:0] fill_ppn,
    input  logic             fill_writable,
    output logic             page_fault,
    input  logic             ref_clear,
    input  logic             flush
);

    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic [VPN_W-1:0]     lk_vpn;
    logic [ENTRIES-1:0]   hit_vec;
    logic [ENTRIES-1:0]   valid_vec;
    logic [ENTRIES-1:0]   ref_vec;
    logic [PPN_W-1:0]     hit_ppn;
    logic                 hit_wr;
    logic                 any_hit;
    logic [IDX_W-1:0]     victim_idx;
    logic                 in_run;
    logic                 capture;
    logic                 inst_en;
    logic [VPN_W-1:0]     pend_vpn_q;
    logic                 is_store;

    assign lk_vpn  = req_vaddr[VA_W-1:PAGE_BITS];
    assign any_hit = |hit_vec;

    tlb_entry_array #(
        .ENTRIES (ENTRIES),
        .VPN_W   (VPN_W),
        .PPN_W   (PPN_W),
        .IDX_W   (IDX_W)
    ) u_array (
        .clk        (clk),
        .rst_n      (rst_n),
        .lookup_vpn (lk_vpn),
        .touch_en   (resp_hit),
        .clear_refs (ref_clear),
        .flush_all  (flush),
        .inst_en    (inst_en),
        .inst_idx   (victim_idx),
        .inst_vpn   (pend_vpn_q),
        .inst_ppn   (fill_ppn),
        .inst_wr    (fill_writable),
        .hit_vec    (hit_vec),
        .hit_ppn    (hit_ppn),
        .hit_wr     (hit_wr),
        .valid_vec  (valid_vec),
        .ref_vec    (ref_vec)
    );

    tlb_victim_pick #(
        .ENTRIES (ENTRIES),
        .IDX_W   (IDX_W)
    ) u_victim (
        .valid_vec  (valid_vec),
        .ref_vec    (ref_vec),
        .victim_idx (victim_idx)
    );

    tlb_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .any_hit      (any_hit),
        .fill_valid   (fill_valid),
        .fill_present (fill_present),
        .flush        (flush),
        .in_run       (in_run),
        .capture      (capture),
        .inst_en      (inst_en),
        .refill_req   (refill_req),
        .page_fault   (page_fault)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_vpn_q <= '0;
        end else if (capture) begin
            pend_vpn_q <= lk_vpn;
        end
    end

    assign is_store   = (req_kind == ACC_STORE);
    assign resp_hit   = req_valid && in_run && any_hit;
    assign resp_miss  = req_valid && in_run && !any_hit;
    assign prot_fault = resp_hit && is_store && !hit_wr;
    assign resp_grant = resp_hit && !(is_store && !hit_wr);
    assign resp_paddr = {hit_ppn, req_vaddr[PAGE_BITS-1:0]};
    assign refill_vpn = pend_vpn_q;

endmodule

// File: rtl/tlb_xlate_chk.sv
module tlb_xlate_chk #(
    parameter int VPN_W     = 20,
    parameter int PPN_W     = 20,
    parameter int PAGE_BITS = 12
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       req_valid,
    input logic [VPN_W+PAGE_BITS-1:0] req_vaddr,
    input logic [1:0]                 req_kind,
    input logic                       resp_hit,
    input logic                       resp_miss,
    input logic                       resp_grant,
    input logic                       prot_fault,
    input logic [PPN_W+PAGE_BITS-1:0] resp_paddr,
    input logic                       refill_req,
    input logic [VPN_W-1:0]           refill_vpn,
    input logic                       fill_valid,
    input logic                       fill_present,
    input logic                       page_fault,
    input logic                       flush
);

    // R1: the page offset passes straight through on a hit
    assert_offset_pass_R1: assert property (@(posedge clk) disable iff (!rst_n)
        resp_hit |-> resp_paddr[PAGE_BITS-1:0] == req_vaddr[PAGE_BITS-1:0]);

    // R2: hit and miss never coincide and need a request
    assert_hit_miss_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_hit || resp_miss) |-> (req_valid && (resp_hit != resp_miss)));

    // R3: a store refused by permission is never granted
    assert_store_protect_R3: assert property (@(posedge clk) disable iff (!rst_n)
        prot_fault |-> (resp_hit && req_kind == 2'd2 && !resp_grant));

    // R3: a fetch or load hit is always granted
    assert_read_grant_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_hit && req_kind != 2'd2) |-> resp_grant);

    // R4: a miss hands over to a refill of the same page
    assert_refill_after_miss_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_miss && !flush) |=>
            (refill_req && refill_vpn == $past(req_vaddr[VPN_W+PAGE_BITS-1:PAGE_BITS])));

    // R4: refill request persists until answered or flushed
    assert_refill_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (refill_req && !fill_valid && !flush) |=> (refill_req && $stable(refill_vpn)));

    // R5: a present refill ends the outstanding request
    assert_fill_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (refill_req && fill_valid && fill_present && !flush) |=> (!refill_req && !page_fault));

    // R6: an absent refill gives a fault pulse of one cycle
    assert_fault_raise_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (refill_req && fill_valid && !fill_present && !flush) |=> page_fault);

    assert_fault_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        page_fault |=> !page_fault);

    // R11: flush drops any pending refill and fault
    assert_flush_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (!refill_req && !page_fault));

    // R12: lookups are silent while a refill or fault is in progress
    assert_busy_silent_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (refill_req || page_fault) |-> (!resp_hit && !resp_miss));

endmodule

bind tlb_xlate tlb_xlate_chk #(
    .VPN_W     (VPN_W),
    .PPN_W     (PPN_W),
    .PAGE_BITS (PAGE_BITS)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_vaddr    (req_vaddr),
    .req_kind     (req_kind),
    .resp_hit     (resp_hit),
    .resp_miss    (resp_miss),
    .resp_grant   (resp_grant),
    .prot_fault   (prot_fault),
    .resp_paddr   (resp_paddr),
    .refill_req   (refill_req),
    .refill_vpn   (refill_vpn),
    .fill_valid   (fill_valid),
    .fill_present (fill_present),
    .page_fault   (page_fault),
    .flush        (flush)
);

// File: tb/tlb_xlate_test.sv
`timescale 1ns/1ps
module tlb_xlate_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic [1:0]  req_kind = 2'd0;
    logic        resp_hit, resp_miss, resp_grant, prot_fault;
    logic [31:0] resp_paddr;
    logic        refill_req;
    logic [19:0] refill_vpn;
    logic        fill_valid = 1'b0;
    logic        fill_present = 1'b0;
    logic [19:0] fill_ppn = '0;
    logic        fill_writable = 1'b0;
    logic        page_fault;
    logic        ref_clear = 1'b0;
    logic        flush = 1'b0;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    tlb_xlate uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .req_kind(req_kind), .resp_hit(resp_hit), .resp_miss(resp_miss),
        .resp_grant(resp_grant), .prot_fault(prot_fault), .resp_paddr(resp_paddr),
        .refill_req(refill_req), .refill_vpn(refill_vpn), .fill_valid(fill_valid),
        .fill_present(fill_present), .fill_ppn(fill_ppn), .fill_writable(fill_writable),
        .page_fault(page_fault), .ref_clear(ref_clear), .flush(flush)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // lookup without a clock edge: no state change
    task automatic probe(input logic [19:0] vpn, input logic [11:0] off, input logic [1:0] kind,
                         input bit eh, input logic [19:0] eppn, input bit ewr, input string tag);
        bit ep;
        @(negedge clk);
        req_valid = 1'b1;
        req_vaddr = {vpn, off};
        req_kind  = kind;
        #1;
        chk({31'd0, resp_hit}, {31'd0, eh}, {tag, " hit"});
        chk({31'd0, resp_miss}, {31'd0, !eh}, {tag, " miss"});
        if (eh) begin
            ep = (kind == 2'd2) && !ewr;
            chk(resp_paddr, {eppn, off}, {tag, " paddr R1"});
            chk({31'd0, prot_fault}, {31'd0, ep}, {tag, " prot R3"});
            chk({31'd0, resp_grant}, {31'd0, !ep}, {tag, " grant R3"});
        end
        #2 req_valid = 1'b0;
    endtask

    // hit with a clock edge, so the reference bit is set
    task automatic touch(input logic [19:0] vpn);
        @(negedge clk);
        req_valid = 1'b1;
        req_vaddr = {vpn, 12'h000};
        req_kind  = 2'd1;
        @(posedge clk);
        #1 req_valid = 1'b0;
    endtask

    task automatic fill_page(input logic [19:0] vpn, input logic [19:0] ppn, input bit wr);
        @(negedge clk);
        req_valid = 1'b1;
        req_vaddr = {vpn, 12'h123};
        req_kind  = 2'd1;
        #1 chk({31'd0, resp_miss}, 32'd1, "miss before refill R2");
        @(negedge clk);
        req_valid = 1'b0;
        chk({31'd0, refill_req}, 32'd1, "refill_req R4");
        chk({12'd0, refill_vpn}, {12'd0, vpn}, "refill_vpn R4");
        fill_valid    = 1'b1;
        fill_present  = 1'b1;
        fill_ppn      = ppn;
        fill_writable = wr;
        @(negedge clk);
        fill_valid = 1'b0;
        chk({31'd0, refill_req}, 32'd0, "refill done R5");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk({31'd0, resp_hit}, 32'd0, "reset hit R2");
        chk({31'd0, refill_req}, 32'd0, "reset refill R4");
        chk({31'd0, page_fault}, 32'd0, "reset fault R6");
        probe(20'h00005, 12'h000, 2'd1, 1'b0, '0, 1'b0, "empty R2");

        // first fill read-only, then R12 check during the wait
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = {20'h00005, 12'h000}; req_kind = 2'd1;
        @(negedge clk);
        chk({31'd0, refill_req}, 32'd1, "wait R4");
        req_vaddr = {20'h00099, 12'h000};
        #1;
        chk({31'd0, resp_hit}, 32'd0, "busy hit R12");
        chk({31'd0, resp_miss}, 32'd0, "busy miss R12");
        req_valid = 1'b0;
        fill_valid = 1'b1; fill_present = 1'b1; fill_ppn = 20'h000AB; fill_writable = 1'b0;
        @(negedge clk);
        fill_valid = 1'b0;

        // offset and access-kind sweep on the read-only page
        for (int k = 0; k < 3; k++) begin
            probe(20'h00005, 12'hFFF - 12'(k * 12'h155), 2'(k), 1'b1, 20'h000AB, 1'b0, "ro sweep R3");
        end
        probe(20'h00005, 12'h000, 2'd2, 1'b1, 20'h000AB, 1'b0, "ro store R3");
        probe(20'h00004, 12'h000, 2'd1, 1'b0, '0, 1'b0, "tag mismatch R2");

        // second fill goes to free entry 1: page 5 survives
        fill_page(20'h00007, 20'h000CD, 1'b1);
        probe(20'h00005, 12'h800, 2'd0, 1'b1, 20'h000AB, 1'b0, "free entry first R7");
        for (int k = 0; k < 3; k++) begin
            probe(20'h00007, 12'h001 + 12'(k), 2'(k), 1'b1, 20'h000CD, 1'b1, "rw sweep R5");
        end

        // all referenced: entry 0 (page 5) replaced
        fill_page(20'h00009, 20'h00011, 1'b1);
        probe(20'h00005, 12'h000, 2'd1, 1'b0, '0, 1'b0, "evict idx0 R9");
        probe(20'h00007, 12'h000, 2'd1, 1'b1, 20'h000CD, 1'b1, "keep idx1 R9");
        probe(20'h00009, 12'h444, 2'd2, 1'b1, 20'h00011, 1'b1, "new in idx0 R5");

        // clear references, touch page 9 (entry 0): entry 1 becomes victim
        @(negedge clk); ref_clear = 1'b1;
        @(negedge clk); ref_clear = 1'b0;
        touch(20'h00009);
        fill_page(20'h0000B, 20'h00022, 1'b0);
        probe(20'h00007, 12'h000, 2'd1, 1'b0, '0, 1'b0, "cold victim R8 R10");
        probe(20'h00009, 12'h000, 2'd1, 1'b1, 20'h00011, 1'b1, "warm kept R8 R10");
        probe(20'h0000B, 12'h000, 2'd2, 1'b1, 20'h00022, 1'b0, "installed ro R8");

        // absent page: one-cycle fault, nothing installed
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = {20'h00033, 12'h000}; req_kind = 2'd0;
        @(negedge clk);
        req_valid = 1'b0;
        fill_valid = 1'b1; fill_present = 1'b0; fill_ppn = 20'h00077;
        @(negedge clk);
        fill_valid = 1'b0;
        chk({31'd0, page_fault}, 32'd1, "fault raised R6");
        chk({31'd0, refill_req}, 32'd0, "fault no refill R6");
        @(negedge clk);
        chk({31'd0, page_fault}, 32'd0, "fault one cycle R6");
        probe(20'h00033, 12'h000, 2'd1, 1'b0, '0, 1'b0, "fault no install R6");
        probe(20'h00009, 12'h000, 2'd1, 1'b1, 20'h00011, 1'b1, "fault keeps R6");

        // flush during a pending refill
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = {20'h00044, 12'h000}; req_kind = 2'd1;
        @(negedge clk);
        req_valid = 1'b0;
        chk({31'd0, refill_req}, 32'd1, "pending before flush R4");
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        chk({31'd0, refill_req}, 32'd0, "flush abandons R11");
        probe(20'h00009, 12'h000, 2'd1, 1'b0, '0, 1'b0, "flush inval a R11");
        probe(20'h0000B, 12'h000, 2'd1, 1'b0, '0, 1'b0, "flush inval b R11");

        // refill after flush lands in entry 0 and works
        fill_page(20'hFFFFF, 20'hABCDE, 1'b1);
        probe(20'hFFFFF, 12'hFFF, 2'd2, 1'b1, 20'hABCDE, 1'b1, "post flush fill R5");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule